// File: doc/BRIEF.md
# Machine Interrupt Enable Register Unit

This block holds the per-source interrupt enable register of a hart's machine privilege level. Software reaches it through a control-register port that can read the register, overwrite it, or set or clear chosen bits atomically. Only the positions assigned to interrupt sources hold state. The counter-overflow enable holds state only when a parameter turns it on.

The same block decides whether a machine-mode interrupt may be taken. It combines the enable register with the pending bits, the delegation mask, the current privilege level and the global machine interrupt enable. The result is a single request line. The read data, the illegal-access flag and the request are all registered. Each appears one clock after the cycle that produced it.

Top module: `mie_csr_unit`

## Requirements
- R1: Only accesses with csr_addr equal to 0x304 act on the block. Any other address leaves the register unchanged, gives read data 0 and does not raise csr_illegal.
- R2: A legal write (csr_op 2'b01) loads csr_wdata into the source enables. Supervisor software is bit 1, machine software bit 3, supervisor timer bit 5, machine timer bit 7, supervisor external bit 9 and machine external bit 11.
- R3: Bit 13, the counter-overflow enable, holds state when LCOF_EN is 1. When LCOF_EN is 0 it reads 0 and ignores every write.
- R4: Every other bit position up to XLEN-1 always reads 0, and writes to it have no effect.
- R5: A legal set (csr_op 2'b10) ORs csr_wdata into the register. Bits that are 0 in the mask keep their values.
- R6: A legal clear (csr_op 2'b11) ANDs the register with the inverted csr_wdata. Bits that are 0 in the mask keep their values.
- R7: A set or clear with an all-zero mask leaves the register unchanged and is still a legal access.
- R8: An access to 0x304 with priv below machine (priv 2'b11; user 2'b00, supervisor 2'b01) leaves the register unchanged. It drives csr_illegal to 1 and csr_rdata to 0 in the following cycle.
- R9: A legal access (any op, including read 2'b00) returns, one cycle later, the register value from before that access.
- R10: m_irq is 1 one cycle after a cycle in which some bit has enable, pending and not-delegated all set, and the effective global enable is 1. Otherwise it is 0.
- R11: A source whose deleg bit is 1 never contributes to m_irq.
- R12: With priv 2'b11 the effective global enable is mstatus_mie. Below machine level it is treated as 1.
- R13: A synchronous reset clears all enables and drives csr_rdata, csr_illegal and m_irq to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_valid | input | 1 | Access request this cycle |
| csr_op | input | 2 | 00 read, 01 write, 10 set, 11 clear |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write value or bit mask |
| priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| mstatus_mie | input | 1 | Global machine interrupt enable |
| pending | input | XLEN | Pending interrupt bits |
| deleg | input | XLEN | Delegation mask, 1 = handled at supervisor level |
| csr_rdata | output | XLEN | Registered read data (old value) |
| csr_illegal | output | 1 | Registered illegal-access flag |
| m_irq | output | 1 | Registered machine interrupt request |

## Verification
Each output of this block is due exactly one rising edge after the cycle that carries its stimulus. That holds for the old-value read data, the illegal flag and the interrupt request. The enable register takes its new value on that same edge, so a change shows on m_irq one edge after the register update. The bench drives inputs on the falling edge and lets one rising edge pass. Its behavioural model predicts the outputs from the pre-update model state, and the bench compares them on the following falling edge.

// File: rtl/mie_pkg.sv
package mie_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  typedef enum logic [1:0] {
    LVL_USER  = 2'b00,
    LVL_SUPV  = 2'b01,
    LVL_RSVD  = 2'b10,
    LVL_MACH  = 2'b11
  } priv_e;

  typedef struct packed {
    logic legal;    // addressed and privileged enough
    logic illegal;  // addressed but privilege too low
    logic update;   // legal and modifies state
  } access_t;
endpackage

// File: rtl/mie_access_dec.sv
module mie_access_dec
  import mie_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 12'h304
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        op,
  input  logic [1:0]        priv,
  output access_t           acc
);
  logic hit;
  logic mach;

  always_comb begin
    hit         = valid && (addr == CSR_ADDR);
    mach        = (priv_e'(priv) == LVL_MACH);
    acc.legal   = hit && mach;
    acc.illegal = hit && !mach;
    acc.update  = hit && mach && (csr_op_e'(op) != OP_READ);
  end
endmodule

// File: rtl/mie_enable_reg.sv
module mie_enable_reg
  import mie_pkg::*;
#(
  parameter int unsigned      XLEN  = 32,
  parameter logic [XLEN-1:0]  WMASK = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            update,
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] en_q
);
  logic unused_wdata;
  assign unused_wdata = ^(wdata & ~WMASK);

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    if (WMASK[i]) begin : g_live
      logic nxt;
      always_comb begin
        unique case (csr_op_e'(op))
          OP_WRITE: nxt = wdata[i];
          OP_SET:   nxt = en_q[i] | wdata[i];
          OP_CLEAR: nxt = en_q[i] & ~wdata[i];
          default:  nxt = en_q[i];
        endcase
      end
      always_ff @(posedge clk) begin
        if (rst)         en_q[i] <= 1'b0;
        else if (update) en_q[i] <= nxt;
      end
    end else begin : g_zero
      assign en_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/mie_irq_gate.sv
module mie_irq_gate
  import mie_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] en,
  input  logic [XLEN-1:0] pend,
  input  logic [XLEN-1:0] deleg,
  input  logic [1:0]      priv,
  input  logic            gie,
  output logic            req
);
  logic gie_eff;
  logic [XLEN-1:0] live;

  always_comb begin
    gie_eff = (priv_e'(priv) == LVL_MACH) ? gie : 1'b1;
    live    = en & pend & ~deleg;
    req     = gie_eff && (|live);
  end
endmodule

// File: rtl/mie_csr_unit.sv
module mie_csr_unit
  import mie_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned ADDR_W   = 12,
  parameter logic [11:0] CSR_ADDR = 12'h304,
  parameter bit          LCOF_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_valid,
  input  logic [1:0]        csr_op,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic [1:0]        priv,
  input  logic              mstatus_mie,
  input  logic [XLEN-1:0]   pending,
  input  logic [XLEN-1:0]   deleg,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_illegal,
  output logic              m_irq
);
  localparam logic [XLEN-1:0] SRC_MASK  = XLEN'(12'hAAA);
  localparam logic [XLEN-1:0] LCOF_MASK = LCOF_EN ? (XLEN'(1) << 13) : '0;
  localparam logic [XLEN-1:0] WMASK     = SRC_MASK | LCOF_MASK;

  access_t         acc;
  logic [XLEN-1:0] en_q;
  logic            req;

  mie_access_dec #(.ADDR_W(ADDR_W), .CSR_ADDR(ADDR_W'(CSR_ADDR))) u_dec (
    .valid (csr_valid),
    .addr  (csr_addr),
    .op    (csr_op),
    .priv  (priv),
    .acc   (acc)
  );

  mie_enable_reg #(.XLEN(XLEN), .WMASK(WMASK)) u_reg (
    .clk    (clk),
    .rst    (rst),
    .update (acc.update),
    .op     (csr_op),
    .wdata  (csr_wdata),
    .en_q   (en_q)
  );

  mie_irq_gate #(.XLEN(XLEN)) u_irq (
    .en    (en_q),
    .pend  (pending),
    .deleg (deleg),
    .priv  (priv),
    .gie   (mstatus_mie),
    .req   (req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata   <= '0;
      csr_illegal <= 1'b0;
      m_irq       <= 1'b0;
    end else begin
      csr_rdata   <= acc.legal ? en_q : '0;
      csr_illegal <= acc.illegal;
      m_irq       <= req;
    end
  end
endmodule

// File: rtl/mie_csr_unit_chk.sv
module mie_csr_unit_chk #(
  parameter int unsigned      XLEN     = 32,
  parameter int unsigned      ADDR_W   = 12,
  parameter logic [11:0]      CSR_ADDR = 12'h304,
  parameter logic [XLEN-1:0]  WMASK    = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              csr_valid,
  input logic [1:0]        csr_op,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [XLEN-1:0]   csr_wdata,
  input logic [1:0]        priv,
  input logic              mstatus_mie,
  input logic [XLEN-1:0]   pending,
  input logic [XLEN-1:0]   deleg,
  input logic [XLEN-1:0]   en_q,
  input logic [XLEN-1:0]   csr_rdata,
  input logic              csr_illegal,
  input logic              m_irq
);
  logic hit, legal;
  assign hit   = csr_valid && (csr_addr == ADDR_W'(CSR_ADDR));
  assign legal = hit && (priv == 2'b11);

  assert_reset_clear_R13: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (en_q == '0 && csr_rdata == '0 && !csr_illegal && !m_irq));

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (csr_rdata & ~WMASK) == '0);

  assert_other_addr_R1: assert property (@(posedge clk) disable iff (rst)
    (csr_valid && !hit) |=> ($stable(en_q) && !csr_illegal && csr_rdata == '0));

  assert_low_priv_R8: assert property (@(posedge clk) disable iff (rst)
    (hit && priv != 2'b11) |=> ($stable(en_q) && csr_illegal && csr_rdata == '0));

  assert_set_R5: assert property (@(posedge clk) disable iff (rst)
    (legal && csr_op == 2'b10) |=>
      (((en_q & $past(csr_wdata) & WMASK) == ($past(csr_wdata) & WMASK)) &&
       ((en_q & ~$past(csr_wdata)) == ($past(en_q) & ~$past(csr_wdata)))));

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (legal && csr_op == 2'b11) |=>
      (((en_q & $past(csr_wdata)) == '0) &&
       ((en_q & ~$past(csr_wdata)) == ($past(en_q) & ~$past(csr_wdata)))));

  assert_old_value_R9: assert property (@(posedge clk) disable iff (rst)
    legal |=> (csr_rdata == $past(en_q)));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && m_irq) |-> $past(|(en_q & pending & ~deleg)));

  assert_irq_gmask_R12: assert property (@(posedge clk) disable iff (rst)
    (priv == 2'b11 && !mstatus_mie) |=> !m_irq);
endmodule

bind mie_csr_unit mie_csr_unit_chk #(
  .XLEN(XLEN), .ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR), .WMASK(WMASK)
) u_chk (
  .clk(clk), .rst(rst), .csr_valid(csr_valid), .csr_op(csr_op),
  .csr_addr(csr_addr), .csr_wdata(csr_wdata), .priv(priv),
  .mstatus_mie(mstatus_mie), .pending(pending), .deleg(deleg),
  .en_q(en_q), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
  .m_irq(m_irq)
);

// File: tb/mie_csr_unit_test.sv
module mie_csr_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam logic [XLEN-1:0] MASK_A = 32'h0000_2AAA;
  localparam logic [XLEN-1:0] MASK_B = 32'h0000_0AAA;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csr_valid = 1'b0;
  logic [1:0] csr_op = 2'b00;
  logic [11:0] csr_addr = 12'h0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [1:0] priv = 2'b11;
  logic mstatus_mie = 1'b0;
  logic [XLEN-1:0] pending = '0;
  logic [XLEN-1:0] deleg = '0;
  logic [XLEN-1:0] rdata_a, rdata_b;
  logic ill_a, ill_b, irq_a, irq_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [XLEN-1:0] mod_a = '0, mod_b = '0;
  logic [XLEN-1:0] exp_rd_a, exp_rd_b;
  logic exp_ill, exp_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  mie_csr_unit #(.XLEN(XLEN), .LCOF_EN(1'b1)) uut (
    .clk(clk), .rst(rst), .csr_valid(csr_valid), .csr_op(csr_op),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .priv(priv),
    .mstatus_mie(mstatus_mie), .pending(pending), .deleg(deleg),
    .csr_rdata(rdata_a), .csr_illegal(ill_a), .m_irq(irq_a));

  mie_csr_unit #(.XLEN(XLEN), .LCOF_EN(1'b0)) uut_lite (
    .clk(clk), .rst(rst), .csr_valid(csr_valid), .csr_op(csr_op),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .priv(priv),
    .mstatus_mie(mstatus_mie), .pending(pending), .deleg(deleg),
    .csr_rdata(rdata_b), .csr_illegal(ill_b), .m_irq(irq_b));

  task automatic check(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] apply(logic [XLEN-1:0] cur, logic [1:0] op,
                                            logic [XLEN-1:0] w, logic [XLEN-1:0] m);
    case (op)
      2'b01:   return w & m;
      2'b10:   return (cur | w) & m;
      2'b11:   return cur & ~w;
      default: return cur;
    endcase
  endfunction

  // One cycle: drive at falling edge, predict, let one rising edge pass, compare.
  task automatic go(string tag, bit v, logic [1:0] op, logic [11:0] a, logic [XLEN-1:0] w,
                    logic [1:0] p, bit g, logic [XLEN-1:0] pe, logic [XLEN-1:0] de);
    bit hit, mach, gie_eff;
    csr_valid = v; csr_op = op; csr_addr = a; csr_wdata = w;
    priv = p; mstatus_mie = g; pending = pe; deleg = de;
    hit = v && (a == 12'h304);
    mach = (p == 2'b11);
    gie_eff = mach ? g : 1'b1;
    exp_rd_a = (hit && mach) ? mod_a : '0;
    exp_rd_b = (hit && mach) ? mod_b : '0;
    exp_ill = hit && !mach;
    exp_irq = gie_eff && ((mod_a & pe & ~de) != '0);
    if (hit && mach) begin
      mod_a = apply(mod_a, op, w, MASK_A);
      mod_b = apply(mod_b, op, w, MASK_B);
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "rdata", rdata_a, exp_rd_a);
    check(tag, "rdata_lite", rdata_b, exp_rd_b);
    check(tag, "illegal", {31'b0, ill_a}, {31'b0, exp_ill});
    check(tag, "irq", {31'b0, irq_a}, {31'b0, exp_irq});
  endtask

  task automatic rd(string tag);
    go(tag, 1, 2'b00, 12'h304, '0, 2'b11, 0, '0, '0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    csr_valid = 1'b0;
    repeat (3) @(negedge clk);
    mod_a = '0; mod_b = '0;
    check("R13", "rdata", rdata_a, '0);
    check("R13", "illegal", {31'b0, ill_a}, '0);
    check("R13", "irq", {31'b0, irq_a}, '0);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    rd("R13");
    // R2 R3 R4: write all ones, readback shows only defined bits
    go("R2", 1, 2'b01, 12'h304, '1, 2'b11, 0, '0, '0);
    rd("R3");
    rd("R4");
    // R6 clear machine timer and software enables
    go("R6", 1, 2'b11, 12'h304, 32'h0000_0088, 2'b11, 0, '0, '0);
    rd("R6");
    // R5 set them back with a partial mask
    go("R5", 1, 2'b10, 12'h304, 32'h0000_0008, 2'b11, 0, '0, '0);
    rd("R5");
    // R7 zero-mask set and clear
    go("R7", 1, 2'b10, 12'h304, '0, 2'b11, 0, '0, '0);
    go("R7", 1, 2'b11, 12'h304, '0, 2'b11, 0, '0, '0);
    rd("R7");
    // R8 low privilege write attempts
    go("R8", 1, 2'b01, 12'h304, '0, 2'b01, 0, '0, '0);
    go("R8", 1, 2'b11, 12'h304, '1, 2'b00, 0, '0, '0);
    rd("R8");
    // R1 other address
    go("R1", 1, 2'b01, 12'h344, '0, 2'b11, 0, '0, '0);
    go("R1", 1, 2'b11, 12'h305, '1, 2'b11, 0, '0, '0);
    rd("R1");
    // R9 write returns old value, then new value
    go("R9", 1, 2'b01, 12'h304, 32'h0000_0080, 2'b11, 0, '0, '0);
    rd("R9");
    // R10 request conditions (only bit 7 enabled)
    go("R10", 0, 2'b00, 12'h0, '0, 2'b11, 1, 32'h0000_0080, '0);
    go("R10", 0, 2'b00, 12'h0, '0, 2'b11, 1, 32'h0000_0800, '0);
    go("R10", 0, 2'b00, 12'h0, '0, 2'b11, 0, 32'h0000_0080, '0);
    // R11 delegated source excluded
    go("R11", 0, 2'b00, 12'h0, '0, 2'b11, 1, 32'h0000_0080, 32'h0000_0080);
    go("R11", 0, 2'b00, 12'h0, '0, 2'b11, 1, 32'h0000_0080, 32'h0000_0800);
    // R12 below machine level the global enable counts as 1
    go("R12", 0, 2'b00, 12'h0, '0, 2'b01, 0, 32'h0000_0080, '0);
    go("R12", 0, 2'b00, 12'h0, '0, 2'b00, 0, 32'h0000_0080, '0);
    // R10 enable change reaches request one edge after the register update
    go("R10", 1, 2'b10, 12'h304, 32'h0000_2000, 2'b11, 1, 32'h0000_2000, '0);
    go("R10", 0, 2'b00, 12'h0, '0, 2'b11, 1, 32'h0000_2000, '0);
    // R13 reset in mid-run clears state
    do_reset();
    rd("R13");
    for (int i = 0; i < 8; i++)
      go("R5", 1, 2'b10, 12'h304, 32'h1 << (2*i+1), 2'b11, 0, '0, '0);
    rd("R3");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule